// File: doc/BRIEF.md
# Four-Channel DMA Programming Port

This block is the processor side of a four-channel DMA controller. The processor reaches it through a 4-bit I/O offset, separate read and write strobes and an 8-bit data bus. Each channel has a 16-bit base address, a 16-bit current address, a 16-bit base word count and a 16-bit current word count. All channels share a command byte, a mode field per channel, a mask per channel, a software request per channel, terminal-count flags and a temporary byte. A transfer engine outside the block reads these values from flat output buses. It reports progress back by loading current addresses and counts, by pulsing terminal-count lines, by driving hardware request lines and by handing over the last byte of a memory-to-memory move.

The processor moves 16-bit values as two byte accesses. A single byte-pointer flip-flop, shared by every channel, chooses the low or the high byte. It toggles on each access to a channel offset and is forced back to the low byte by a dedicated clear offset. At the same even offset, a write programs the base address and a read returns the current address. Writes are sampled on the rising clock edge. Read data is combinational while the read strobe is high, and any side effect of the read (pointer toggle, flag clear) takes place at the closing edge.

Top module: `dma4_regport`

## Requirements
- R1: After reset all four mask bits are 1. The command byte, software requests, terminal-count flags and temporary byte are 0, and the byte pointer selects the low byte.
- R2: A write to an even offset 2*n (n = 0..3) loads the selected byte of channel n's base address, and also of its current address. A read there returns the selected byte of the current address.
- R3: A write to an odd offset 2*n+1 loads the selected byte of channel n's base word count, and also of its current word count. A read there returns the selected byte of the current word count.
- R4: One byte pointer serves all channel offsets 0..7. Low byte [7:0] is selected when it is 0 and high byte [15:8] when it is 1. Every read or write at offsets 0..7 toggles it. A write of any data to offset 0xC sets it to 0.
- R5: A write of any data to offset 0xD is a master clear that restores the R1 state of the shared registers. A read at 0xD returns the temporary byte, which loads from eng_tmp_data whenever eng_tmp_valid is high.
- R6: A write of any data to offset 0xE clears all four mask bits. A write to 0xF loads mask[3:0] from data bits 3..0. A read at 0xF returns {4'b0, mask}.
- R7: A write to offset 0xA sets (bit 2 = 1) or clears (bit 2 = 0) the mask bit of the channel that data bits 1..0 select.
- R8: A write to offset 0x9 sets or clears the software request of the channel that bits 1..0 select, according to bit 2. A read of status at 0x8 shows, in bits 7..4, the OR of the software request and hw_req for channels 3..0.
- R9: Status bits 3..0 are the terminal-count flags of channels 3..0. A status read clears them. A terminal-count pulse in the same cycle as the read remains set afterwards.
- R10: A high bit of eng_tc sets both the terminal-count flag and the mask bit of that channel on the next edge.
- R11: When eng_upd_valid is high, channel eng_upd_chan loads its current address and current count from eng_upd_addr and eng_upd_count. Its base registers stay unchanged.
- R12: A write to 0x8 loads the command byte. A write to 0xB stores data bits 7..2 as the mode of the channel that bits 1..0 select. Mode n appears on mode_o[6n+5:6n].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_off | input | 4 | Register offset |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data (0 when io_rd is low) |
| hw_req | input | 4 | Hardware request lines, channels 3..0 |
| eng_tc | input | 4 | Terminal-count pulses from the engine |
| eng_upd_valid | input | 1 | Engine loads current address and count |
| eng_upd_chan | input | 2 | Channel of the engine update |
| eng_upd_addr | input | 16 | New current address |
| eng_upd_count | input | 16 | New current word count |
| eng_tmp_valid | input | 1 | Engine loads the temporary byte |
| eng_tmp_data | input | 8 | Byte for the temporary register |
| base_addr_o | output | 64 | Base addresses, channel n at [16n+15:16n] |
| cur_addr_o | output | 64 | Current addresses |
| base_cnt_o | output | 64 | Base word counts |
| cur_cnt_o | output | 64 | Current word counts |
| mode_o | output | 24 | Mode fields, 6 bits per channel |
| cmd_o | output | 8 | Command byte |
| mask_o | output | 4 | Channel masks |
| sw_req_o | output | 4 | Software requests |

## Verification
The hardest state to reach is a byte pointer that is out of step. Software normally keeps it even, and its value never appears on a port. The bench leaves it on the high byte on purpose: a lone low-byte write, a read of an address offset, or a write to another channel's count. It then watches where the next byte lands in the flat base buses. The collision between a status read and a terminal-count pulse in the same cycle is another hard case. The bench raises both on the same falling edge.

// File: rtl/dma4_pkg.sv
package dma4_pkg;
    localparam int NUM_CH  = 4;
    localparam int CH_W    = $clog2(NUM_CH);
    localparam int BYTE_W  = 8;
    localparam int REG_W   = 2 * BYTE_W;
    localparam int MODE_W  = BYTE_W - CH_W;
    localparam int OFF_W   = 4;

    localparam logic [OFF_W-1:0] OFF_STATUS  = 4'h8;
    localparam logic [OFF_W-1:0] OFF_REQ     = 4'h9;
    localparam logic [OFF_W-1:0] OFF_MASK1   = 4'hA;
    localparam logic [OFF_W-1:0] OFF_MODE    = 4'hB;
    localparam logic [OFF_W-1:0] OFF_PTRCLR  = 4'hC;
    localparam logic [OFF_W-1:0] OFF_MCLR    = 4'hD;
    localparam logic [OFF_W-1:0] OFF_MASKCLR = 4'hE;
    localparam logic [OFF_W-1:0] OFF_MASKALL = 4'hF;

    typedef struct packed {
        logic [REG_W-1:0]  base_addr;
        logic [REG_W-1:0]  cur_addr;
        logic [REG_W-1:0]  base_cnt;
        logic [REG_W-1:0]  cur_cnt;
        logic [MODE_W-1:0] mode;
    } chan_regs_t;

    typedef struct packed {
        logic              ptr;
        logic [NUM_CH-1:0] mask;
        logic [NUM_CH-1:0] sw_req;
        logic [NUM_CH-1:0] tc;
        logic [BYTE_W-1:0] cmd;
        logic [BYTE_W-1:0] temp;
    } ctrl_regs_t;
endpackage

// File: rtl/dma4_decode.sv
module dma4_decode
    import dma4_pkg::*;
(
    input  logic [OFF_W-1:0] off,
    input  logic             rd,
    input  logic             wr,
    output logic             chan_acc,
    output logic             chan_wr,
    output logic             is_count,
    output logic [CH_W-1:0]  chan,
    output logic             wr_cmd,
    output logic             wr_req,
    output logic             wr_mask1,
    output logic             wr_mode,
    output logic             wr_ptrclr,
    output logic             wr_mclr,
    output logic             wr_maskclr,
    output logic             wr_maskall,
    output logic             rd_status
);
    localparam logic [OFF_W-1:0] CHAN_LIMIT = OFF_W'(2 * NUM_CH);

    logic in_chan_range;

    always_comb begin
        in_chan_range = (off < CHAN_LIMIT);
        chan_acc      = in_chan_range && (rd || wr);
        chan_wr       = in_chan_range && wr;
        is_count      = off[0];
        chan          = off[CH_W:1];
        wr_cmd        = wr && (off == OFF_STATUS);
        wr_req        = wr && (off == OFF_REQ);
        wr_mask1      = wr && (off == OFF_MASK1);
        wr_mode       = wr && (off == OFF_MODE);
        wr_ptrclr     = wr && (off == OFF_PTRCLR);
        wr_mclr       = wr && (off == OFF_MCLR);
        wr_maskclr    = wr && (off == OFF_MASKCLR);
        wr_maskall    = wr && (off == OFF_MASKALL);
        rd_status     = rd && (off == OFF_STATUS);
    end
endmodule

// File: rtl/dma4_chan.sv
module dma4_chan
    import dma4_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              is_count,
    input  logic              hi,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              mode_wr,
    input  logic [MODE_W-1:0] mode_bits,
    input  logic              upd_valid,
    input  logic [REG_W-1:0]  upd_addr,
    input  logic [REG_W-1:0]  upd_count,
    output logic [REG_W-1:0]  base_addr,
    output logic [REG_W-1:0]  cur_addr,
    output logic [REG_W-1:0]  base_cnt,
    output logic [REG_W-1:0]  cur_cnt,
    output logic [MODE_W-1:0] mode
);
    chan_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        // engine progress first, so a processor write in the same cycle wins
        if (upd_valid) begin
            regs_d.cur_addr = upd_addr;
            regs_d.cur_cnt  = upd_count;
        end
        if (wr_en) begin
            if (!is_count) begin
                if (hi) begin
                    regs_d.base_addr[REG_W-1:BYTE_W] = wdata;
                    regs_d.cur_addr[REG_W-1:BYTE_W]  = wdata;
                end else begin
                    regs_d.base_addr[BYTE_W-1:0] = wdata;
                    regs_d.cur_addr[BYTE_W-1:0]  = wdata;
                end
            end else begin
                if (hi) begin
                    regs_d.base_cnt[REG_W-1:BYTE_W] = wdata;
                    regs_d.cur_cnt[REG_W-1:BYTE_W]  = wdata;
                end else begin
                    regs_d.base_cnt[BYTE_W-1:0] = wdata;
                    regs_d.cur_cnt[BYTE_W-1:0]  = wdata;
                end
            end
        end
        if (mode_wr) begin
            regs_d.mode = mode_bits;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign base_addr = regs_q.base_addr;
    assign cur_addr  = regs_q.cur_addr;
    assign base_cnt  = regs_q.base_cnt;
    assign cur_cnt   = regs_q.cur_cnt;
    assign mode      = regs_q.mode;
endmodule

// File: rtl/dma4_ctrl.sv
module dma4_ctrl
    import dma4_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chan_acc,
    input  logic              wr_cmd,
    input  logic              wr_req,
    input  logic              wr_mask1,
    input  logic              wr_ptrclr,
    input  logic              wr_mclr,
    input  logic              wr_maskclr,
    input  logic              wr_maskall,
    input  logic              rd_status,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [NUM_CH-1:0] eng_tc,
    input  logic              tmp_valid,
    input  logic [BYTE_W-1:0] tmp_data,
    output logic              ptr,
    output logic [NUM_CH-1:0] mask,
    output logic [NUM_CH-1:0] sw_req,
    output logic [NUM_CH-1:0] tc,
    output logic [BYTE_W-1:0] cmd,
    output logic [BYTE_W-1:0] temp
);
    localparam ctrl_regs_t CLEAR_VAL = '{
        ptr:    1'b0,
        mask:   {NUM_CH{1'b1}},
        sw_req: '0,
        tc:     '0,
        cmd:    '0,
        temp:   '0
    };

    ctrl_regs_t ctrl_d, ctrl_q;
    logic [CH_W-1:0] sel_ch;
    logic            sel_set;

    always_comb begin
        sel_ch  = wdata[CH_W-1:0];
        sel_set = wdata[CH_W];
        ctrl_d  = ctrl_q;

        if (chan_acc)  ctrl_d.ptr = ~ctrl_q.ptr;
        if (wr_ptrclr) ctrl_d.ptr = 1'b0;

        if (wr_cmd) ctrl_d.cmd = wdata;
        if (wr_req) ctrl_d.sw_req[sel_ch] = sel_set;

        if (wr_mask1)   ctrl_d.mask[sel_ch] = sel_set;
        if (wr_maskclr) ctrl_d.mask = '0;
        if (wr_maskall) ctrl_d.mask = wdata[NUM_CH-1:0];

        if (rd_status) ctrl_d.tc = '0;
        // terminal count beats a clear in the same cycle
        ctrl_d.tc   = ctrl_d.tc | eng_tc;
        ctrl_d.mask = ctrl_d.mask | eng_tc;

        if (tmp_valid) ctrl_d.temp = tmp_data;

        if (wr_mclr) ctrl_d = CLEAR_VAL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= CLEAR_VAL;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign ptr    = ctrl_q.ptr;
    assign mask   = ctrl_q.mask;
    assign sw_req = ctrl_q.sw_req;
    assign tc     = ctrl_q.tc;
    assign cmd    = ctrl_q.cmd;
    assign temp   = ctrl_q.temp;
endmodule

// File: rtl/dma4_regport.sv
module dma4_regport
    import dma4_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [OFF_W-1:0]          io_off,
    input  logic                      io_rd,
    input  logic                      io_wr,
    input  logic [BYTE_W-1:0]         io_wdata,
    output logic [BYTE_W-1:0]         io_rdata,
    input  logic [NUM_CH-1:0]         hw_req,
    input  logic [NUM_CH-1:0]         eng_tc,
    input  logic                      eng_upd_valid,
    input  logic [CH_W-1:0]           eng_upd_chan,
    input  logic [REG_W-1:0]          eng_upd_addr,
    input  logic [REG_W-1:0]          eng_upd_count,
    input  logic                      eng_tmp_valid,
    input  logic [BYTE_W-1:0]         eng_tmp_data,
    output logic [NUM_CH*REG_W-1:0]   base_addr_o,
    output logic [NUM_CH*REG_W-1:0]   cur_addr_o,
    output logic [NUM_CH*REG_W-1:0]   base_cnt_o,
    output logic [NUM_CH*REG_W-1:0]   cur_cnt_o,
    output logic [NUM_CH*MODE_W-1:0]  mode_o,
    output logic [BYTE_W-1:0]         cmd_o,
    output logic [NUM_CH-1:0]         mask_o,
    output logic [NUM_CH-1:0]         sw_req_o
);
    logic            chan_acc, chan_wr, is_count;
    logic [CH_W-1:0] chan;
    logic            wr_cmd, wr_req, wr_mask1, wr_mode, wr_ptrclr;
    logic            wr_mclr, wr_maskclr, wr_maskall, rd_status;

    logic              byte_hi;
    logic [NUM_CH-1:0] tc_flags;
    logic [BYTE_W-1:0] temp_byte;

    logic [REG_W-1:0] cur_addr_a [NUM_CH];
    logic [REG_W-1:0] cur_cnt_a  [NUM_CH];

    dma4_decode u_dec (
        .off        (io_off),
        .rd         (io_rd),
        .wr         (io_wr),
        .chan_acc   (chan_acc),
        .chan_wr    (chan_wr),
        .is_count   (is_count),
        .chan       (chan),
        .wr_cmd     (wr_cmd),
        .wr_req     (wr_req),
        .wr_mask1   (wr_mask1),
        .wr_mode    (wr_mode),
        .wr_ptrclr  (wr_ptrclr),
        .wr_mclr    (wr_mclr),
        .wr_maskclr (wr_maskclr),
        .wr_maskall (wr_maskall),
        .rd_status  (rd_status)
    );

    dma4_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .chan_acc   (chan_acc),
        .wr_cmd     (wr_cmd),
        .wr_req     (wr_req),
        .wr_mask1   (wr_mask1),
        .wr_ptrclr  (wr_ptrclr),
        .wr_mclr    (wr_mclr),
        .wr_maskclr (wr_maskclr),
        .wr_maskall (wr_maskall),
        .rd_status  (rd_status),
        .wdata      (io_wdata),
        .eng_tc     (eng_tc),
        .tmp_valid  (eng_tmp_valid),
        .tmp_data   (eng_tmp_data),
        .ptr        (byte_hi),
        .mask       (mask_o),
        .sw_req     (sw_req_o),
        .tc         (tc_flags),
        .cmd        (cmd_o),
        .temp       (temp_byte)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        logic [REG_W-1:0]  base_addr_w, base_cnt_w;
        logic [MODE_W-1:0] mode_w;

        dma4_chan u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (chan_wr && (chan == CH_W'(g))),
            .is_count  (is_count),
            .hi        (byte_hi),
            .wdata     (io_wdata),
            .mode_wr   (wr_mode && (io_wdata[CH_W-1:0] == CH_W'(g))),
            .mode_bits (io_wdata[BYTE_W-1:CH_W]),
            .upd_valid (eng_upd_valid && (eng_upd_chan == CH_W'(g))),
            .upd_addr  (eng_upd_addr),
            .upd_count (eng_upd_count),
            .base_addr (base_addr_w),
            .cur_addr  (cur_addr_a[g]),
            .base_cnt  (base_cnt_w),
            .cur_cnt   (cur_cnt_a[g]),
            .mode      (mode_w)
        );

        assign base_addr_o[g*REG_W +: REG_W] = base_addr_w;
        assign cur_addr_o[g*REG_W +: REG_W]  = cur_addr_a[g];
        assign base_cnt_o[g*REG_W +: REG_W]  = base_cnt_w;
        assign cur_cnt_o[g*REG_W +: REG_W]   = cur_cnt_a[g];
        assign mode_o[g*MODE_W +: MODE_W]    = mode_w;
    end

    logic [REG_W-1:0]  rd_word;
    logic [BYTE_W-1:0] rd_mux;

    always_comb begin
        rd_word = is_count ? cur_cnt_a[chan] : cur_addr_a[chan];
        rd_mux  = '0;
        if (io_off < OFF_W'(2 * NUM_CH)) begin
            rd_mux = byte_hi ? rd_word[REG_W-1:BYTE_W] : rd_word[BYTE_W-1:0];
        end else begin
            case (io_off)
                OFF_STATUS:  rd_mux = {sw_req_o | hw_req, tc_flags};
                OFF_MCLR:    rd_mux = temp_byte;
                OFF_MASKALL: rd_mux = {{(BYTE_W-NUM_CH){1'b0}}, mask_o};
                default:     rd_mux = '0;
            endcase
        end
        io_rdata = io_rd ? rd_mux : '0;
    end
endmodule

module dma4_regport_chk
    import dma4_pkg::*;
(
    input logic                    clk,
    input logic                    rst_n,
    input logic [OFF_W-1:0]        io_off,
    input logic                    io_rd,
    input logic                    io_wr,
    input logic [BYTE_W-1:0]       io_wdata,
    input logic [NUM_CH-1:0]       eng_tc,
    input logic                    eng_upd_valid,
    input logic [NUM_CH-1:0]       mask_o,
    input logic [NUM_CH-1:0]       sw_req_o,
    input logic                    byte_hi,
    input logic [NUM_CH-1:0]       tc_flags,
    input logic [NUM_CH*REG_W-1:0] cur_addr_o
);
    // R5
    mclr_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_off == OFF_MCLR)
        |=> (mask_o == {NUM_CH{1'b1}} && sw_req_o == '0 && !byte_hi && tc_flags == '0));

    // R6
    mask_clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_off == OFF_MASKCLR && eng_tc == '0) |=> (mask_o == '0));

    // R10
    tc_sets_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_tc != '0 && !(io_wr && io_off == OFF_MCLR))
        |=> (((mask_o & $past(eng_tc)) == $past(eng_tc))
             && ((tc_flags & $past(eng_tc)) == $past(eng_tc))));

    // R4
    ptr_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((io_rd || io_wr) && io_off < OFF_W'(2 * NUM_CH)) |=> (byte_hi != $past(byte_hi)));

    // R4
    ptr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_off == OFF_PTRCLR) |=> !byte_hi);

    // R9
    status_rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && io_off == OFF_STATUS && eng_tc == '0) |=> (tc_flags == '0));

    // R2
    base_lo_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_off == 4'h0 && !byte_hi && !eng_upd_valid)
        |=> (cur_addr_o[BYTE_W-1:0] == $past(io_wdata)));
endmodule

bind dma4_regport dma4_regport_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .io_off        (io_off),
    .io_rd         (io_rd),
    .io_wr         (io_wr),
    .io_wdata      (io_wdata),
    .eng_tc        (eng_tc),
    .eng_upd_valid (eng_upd_valid),
    .mask_o        (mask_o),
    .sw_req_o      (sw_req_o),
    .byte_hi       (byte_hi),
    .tc_flags      (tc_flags),
    .cur_addr_o    (cur_addr_o)
);

// File: tb/tb_dma4_regport.sv
module tb_dma4_regport;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  io_off = '0;
    logic        io_rd = 1'b0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic [3:0]  hw_req = '0;
    logic [3:0]  eng_tc = '0;
    logic        eng_upd_valid = 1'b0;
    logic [1:0]  eng_upd_chan = '0;
    logic [15:0] eng_upd_addr = '0;
    logic [15:0] eng_upd_count = '0;
    logic        eng_tmp_valid = 1'b0;
    logic [7:0]  eng_tmp_data = '0;
    logic [63:0] base_addr_o, cur_addr_o, base_cnt_o, cur_cnt_o;
    logic [23:0] mode_o;
    logic [7:0]  cmd_o;
    logic [3:0]  mask_o, sw_req_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma4_regport dut (
        .clk(clk), .rst_n(rst_n), .io_off(io_off), .io_rd(io_rd), .io_wr(io_wr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .hw_req(hw_req), .eng_tc(eng_tc),
        .eng_upd_valid(eng_upd_valid), .eng_upd_chan(eng_upd_chan),
        .eng_upd_addr(eng_upd_addr), .eng_upd_count(eng_upd_count),
        .eng_tmp_valid(eng_tmp_valid), .eng_tmp_data(eng_tmp_data),
        .base_addr_o(base_addr_o), .cur_addr_o(cur_addr_o), .base_cnt_o(base_cnt_o),
        .cur_cnt_o(cur_cnt_o), .mode_o(mode_o), .cmd_o(cmd_o), .mask_o(mask_o),
        .sw_req_o(sw_req_o)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] actual, input logic [63:0] expected);
        n_checks++;
        if (actual !== expected) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, actual, expected);
        end
    endtask

    task automatic io_write(input logic [3:0] off, input logic [7:0] data);
        @(negedge clk);
        io_off = off; io_wdata = data; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic io_read(input logic [3:0] off, output logic [7:0] data);
        @(negedge clk);
        io_off = off; io_rd = 1'b1;
        #1 data = io_rdata;
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check("R1", "mask after reset", 64'(mask_o), 64'hF);
        check("R1", "sw_req after reset", 64'(sw_req_o), 64'h0);
        check("R1", "cmd after reset", 64'(cmd_o), 64'h0);
        io_read(4'h8, v); check("R1", "status after reset", 64'(v), 64'h0);
        io_read(4'hD, v); check("R1", "temp after reset", 64'(v), 64'h0);
    endtask

    task automatic t_addr();
        logic [7:0] v;
        io_write(4'h0, 8'h34); io_write(4'h0, 8'h12);
        check("R2", "ch0 base addr", 64'(base_addr_o[15:0]), 64'h1234);
        check("R2", "ch0 cur addr", 64'(cur_addr_o[15:0]), 64'h1234);
        io_write(4'h4, 8'hCD); io_write(4'h4, 8'hAB);
        check("R2", "ch2 base addr", 64'(base_addr_o[47:32]), 64'hABCD);
        io_read(4'h0, v); check("R2", "ch0 read low", 64'(v), 64'h34);
        io_read(4'h0, v); check("R2", "ch0 read high", 64'(v), 64'h12);
        io_read(4'h4, v); check("R2", "ch2 read low", 64'(v), 64'hCD);
        io_read(4'h4, v); check("R2", "ch2 read high", 64'(v), 64'hAB);
    endtask

    task automatic t_count();
        logic [7:0] v;
        io_write(4'h3, 8'h10); io_write(4'h3, 8'h02);
        check("R3", "ch1 base count", 64'(base_cnt_o[31:16]), 64'h0210);
        check("R3", "ch1 cur count", 64'(cur_cnt_o[31:16]), 64'h0210);
        io_read(4'h3, v); check("R3", "ch1 count low", 64'(v), 64'h10);
        io_read(4'h3, v); check("R3", "ch1 count high", 64'(v), 64'h02);
    endtask

    task automatic t_ptr();
        logic [7:0] v;
        io_write(4'hC, 8'hA5);
        io_write(4'h0, 8'h55);
        io_write(4'hC, 8'h3C);
        io_write(4'h0, 8'h66);
        check("R4", "ptr clear returns to low byte", 64'(base_addr_o[15:0]), 64'h1266);
        io_write(4'h1, 8'h88);
        check("R4", "shared ptr into ch0 count high", 64'(base_cnt_o[15:0]), 64'h8800);
        io_read(4'h0, v);
        check("R4", "read at low byte", 64'(v), 64'h66);
        io_write(4'h0, 8'h99);
        check("R4", "read toggled ptr", 64'(base_addr_o[15:0]), 64'h9966);
    endtask

    task automatic t_mask();
        logic [7:0] v;
        io_write(4'hE, 8'h5A);
        check("R6", "clear all masks", 64'(mask_o), 64'h0);
        io_write(4'hA, 8'h05);
        check("R7", "set mask ch1", 64'(mask_o), 64'h2);
        io_write(4'hA, 8'h06);
        check("R7", "set mask ch2", 64'(mask_o), 64'h6);
        io_write(4'hA, 8'h01);
        check("R7", "clear mask ch1", 64'(mask_o), 64'h4);
        io_write(4'hF, 8'hF9);
        check("R6", "load all masks", 64'(mask_o), 64'h9);
        io_read(4'hF, v);
        check("R6", "read masks", 64'(v), 64'h09);
    endtask

    task automatic t_req();
        logic [7:0] v;
        io_write(4'h9, 8'h07);
        check("R8", "sw request ch3", 64'(sw_req_o), 64'h8);
        hw_req = 4'b0001;
        io_read(4'h8, v);
        check("R8", "status request bits", 64'(v), 64'h90);
        hw_req = 4'b0000;
        io_write(4'h9, 8'h03);
        check("R8", "sw request cleared", 64'(sw_req_o), 64'h0);
    endtask

    task automatic t_tc();
        logic [7:0] v;
        io_write(4'hE, 8'h00);
        @(negedge clk); eng_tc = 4'b0010;
        @(negedge clk); eng_tc = 4'b0000;
        check("R10", "tc sets mask ch1", 64'(mask_o), 64'h2);
        io_read(4'h8, v); check("R9", "status tc ch1", 64'(v), 64'h02);
        io_read(4'h8, v); check("R9", "status cleared by read", 64'(v), 64'h00);
        @(negedge clk);
        io_off = 4'h8; io_rd = 1'b1; eng_tc = 4'b0100;
        #1 v = io_rdata;
        @(negedge clk);
        io_rd = 1'b0; eng_tc = 4'b0000;
        check("R9", "status during collision", 64'(v), 64'h00);
        io_read(4'h8, v); check("R9", "tc kept through same-cycle read", 64'(v), 64'h04);
        check("R10", "mask ch2 after tc", 64'(mask_o), 64'h6);
    endtask

    task automatic t_upd();
        logic [7:0] v;
        @(negedge clk);
        eng_upd_valid = 1'b1; eng_upd_chan = 2'd2;
        eng_upd_addr = 16'hBEEF; eng_upd_count = 16'h0042;
        @(negedge clk);
        eng_upd_valid = 1'b0;
        check("R11", "ch2 cur addr", 64'(cur_addr_o[47:32]), 64'hBEEF);
        check("R11", "ch2 cur count", 64'(cur_cnt_o[47:32]), 64'h0042);
        check("R11", "ch2 base addr kept", 64'(base_addr_o[47:32]), 64'hABCD);
        check("R11", "ch1 cur addr untouched", 64'(cur_addr_o[31:16]), 64'h0000);
        io_write(4'hC, 8'hFF);
        io_read(4'h4, v); check("R11", "read cur addr low", 64'(v), 64'hEF);
        io_read(4'h4, v); check("R11", "read cur addr high", 64'(v), 64'hBE);
        io_read(4'h5, v); check("R11", "read cur count low", 64'(v), 64'h42);
    endtask

    task automatic t_cmd_mode();
        io_write(4'h8, 8'h24);
        check("R12", "command byte", 64'(cmd_o), 64'h24);
        io_write(4'hB, 8'h4A);
        check("R12", "mode ch2", 64'(mode_o[17:12]), 64'h12);
        check("R12", "mode ch0 untouched", 64'(mode_o[5:0]), 64'h00);
    endtask

    task automatic t_mclr();
        logic [7:0] v;
        io_write(4'hC, 8'h00);
        @(negedge clk); eng_tmp_valid = 1'b1; eng_tmp_data = 8'h5A;
        @(negedge clk); eng_tmp_valid = 1'b0;
        io_read(4'hD, v); check("R5", "temp byte", 64'(v), 64'h5A);
        io_write(4'h9, 8'h04);
        io_write(4'hE, 8'h00);
        io_write(4'h0, 8'h11);
        io_write(4'hD, 8'h77);
        check("R5", "mask after master clear", 64'(mask_o), 64'hF);
        check("R5", "sw_req after master clear", 64'(sw_req_o), 64'h0);
        check("R5", "cmd after master clear", 64'(cmd_o), 64'h00);
        io_read(4'hD, v); check("R5", "temp after master clear", 64'(v), 64'h00);
        io_read(4'h8, v); check("R5", "status after master clear", 64'(v), 64'h00);
        io_write(4'h0, 8'h22);
        check("R5", "ptr low after master clear", 64'(base_addr_o[15:0]), 64'h9922);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_addr();
        t_count();
        t_ptr();
        t_mask();
        t_req();
        t_tc();
        t_upd();
        t_cmd_mode();
        t_mclr();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule